// File: doc/BRIEF.md
# LIN Response Length Controller

This block runs the data phase of one response for a single LIN node, sending or receiving. Before the command, a host writes a transmit length and a receive length. A response command then picks a direction and clamps that direction's length to eight bytes. From then on the block counts the data bytes that a byte-level serial engine hands over or accepts. The count appears in the length field of the other direction, so the host can still read it after the response ends. The block flags the byte that must be the checksum, and it raises a one-cycle done pulse when that byte completes.

The block also holds the 6-bit bit-time value that the bit sampler uses for oversampling. After every response this value returns to 32, unless the host has turned resynchronization off. While the controller is disabled, the host may write the value, with a floor of 8. A slave node with resynchronization on may take a measured value from the sampler. A master node never does.

Top module: `lin_resp_len`

## Requirements
- R1: During and after reset, txLen and rxLen are 0, busy and respDone are 0, bitTime is 32 and resyncOff is 0.
- R2: A lenWr pulse while idle stores lenTxIn into txLen and lenRxIn into rxLen as written, with no clamping. A lenWr pulse while busy is ignored.
- R3: A cmdStart pulse with cmdTx=1 (transmit) or cmdTx=0 (receive) raises busy. On the next cycle the chosen direction's field reads min(value, 8) and the opposite field reads 0.
- R4: While busy, each byteDone on a data byte adds one to the opposite field: rxLen counts bytes sent in transmit, txLen counts bytes received in receive.
- R5: isChecksum is 1 exactly while busy and the count equals the length. With a length of 0, the first byte is the checksum.
- R6: A byteDone on the checksum byte clears busy and pulses respDone for one cycle. Both fields keep their values.
- R7: A byteErr while busy clears busy without respDone, and both fields hold the progress made so far.
- R8: When a response ends, by done or by error, bitTime reloads to 32 if resyncOff is 0. It is kept if resyncOff is 1.
- R9: A btWr while enable=0 works as follows. With btNoResync=0 it sets bitTime to 32 and resyncOff to 0. With btNoResync=1 it sets bitTime to max(btIn, 8) and resyncOff to 1. A btWr while enable=1 has no effect.
- R10: A resyncValid while enable=1, isMaster=0 and resyncOff=0 sets bitTime to max(resyncBt, 8). It is ignored for a master or when resyncOff=1. The end-of-response reload wins over a resync in the same cycle.
- R11: A cmdStart takes priority over a byteDone or byteErr in the same cycle. The response restarts with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enabled |
| isMaster | input | 1 | Node configured as master |
| lenWr | input | 1 | Write both length fields |
| lenTxIn | input | 4 | Transmit length to write |
| lenRxIn | input | 4 | Receive length to write |
| cmdStart | input | 1 | Start a response |
| cmdTx | input | 1 | 1 = transmit response, 0 = receive |
| byteDone | input | 1 | Byte engine completed a byte |
| byteErr | input | 1 | Byte engine aborted the response |
| btWr | input | 1 | Write bit-time register |
| btIn | input | 6 | Bit-time value to write |
| btNoResync | input | 1 | Resync-disable bit written with btIn |
| resyncValid | input | 1 | Measured bit-time available |
| resyncBt | input | 6 | Measured bit-time |
| txLen | output | 4 | Transmit length, or receive progress |
| rxLen | output | 4 | Receive length, or transmit progress |
| isChecksum | output | 1 | Current byte is the checksum |
| busy | output | 1 | Response in progress |
| respDone | output | 1 | One-cycle pulse after checksum byte |
| bitTime | output | 6 | Current bit-time value |
| resyncOff | output | 1 | Resynchronization disabled |

## Verification
Two functions can land on the same edge: the end-of-response reload of the bit time, and a resync update from the sampler. The bench raises resyncValid with a measured value of 40 on the same edge as the final checksum byteDone. The check expects bitTime to read 32 on the next cycle. A second collision, cmdStart together with byteDone, is judged by the count staying at 0 rather than advancing.

// File: rtl/lrl_pkg.sv
package lrl_pkg;
  typedef struct packed {
    logic wrLen;
    logic load;
    logic dirTx;
    logic count;
    logic endResp;
  } lrlStrobe_t;
endpackage

// File: rtl/lrl_ctrl.sv
module lrl_ctrl
  import lrl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lenWr,
  input  logic       cmdStart,
  input  logic       cmdTx,
  input  logic       byteDone,
  input  logic       byteErr,
  input  logic       atChecksum,
  output lrlStrobe_t st,
  output logic       busy,
  output logic       respDone
);
  logic busyQ, dirQ, doneQ;

  always_comb begin
    st = '0;
    st.dirTx = cmdStart ? cmdTx : dirQ;
    st.wrLen = lenWr && !busyQ && !cmdStart;
    if (cmdStart) st.load = 1'b1;
    else if (busyQ && byteErr) st.endResp = 1'b1;
    else if (busyQ && byteDone) begin
      if (atChecksum) st.endResp = 1'b1;
      else            st.count = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      dirQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= !cmdStart && busyQ && byteDone && !byteErr && atChecksum;
      if (st.load) begin
        busyQ <= 1'b1;
        dirQ  <= cmdTx;
      end else if (st.endResp) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign busy     = busyQ;
  assign respDone = doneQ;
endmodule

// File: rtl/lrl_dp.sv
module lrl_dp
  import lrl_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int MAX_LEN = 8,
  parameter int BT_W   = 6,
  parameter int BT_RST = 32,
  parameter int BT_MIN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  lrlStrobe_t       st,
  input  logic [LEN_W-1:0] lenTxIn,
  input  logic [LEN_W-1:0] lenRxIn,
  input  logic             enable,
  input  logic             isMaster,
  input  logic             btWr,
  input  logic [BT_W-1:0]  btIn,
  input  logic             btNoResync,
  input  logic             resyncValid,
  input  logic [BT_W-1:0]  resyncBt,
  output logic [LEN_W-1:0] txLen,
  output logic [LEN_W-1:0] rxLen,
  output logic [BT_W-1:0]  bitTime,
  output logic             resyncOff,
  output logic             atChecksum
);
  localparam logic [LEN_W-1:0] MaxL  = LEN_W'(MAX_LEN);
  localparam logic [BT_W-1:0]  BtRst = BT_W'(BT_RST);
  localparam logic [BT_W-1:0]  BtMin = BT_W'(BT_MIN);

  logic [LEN_W-1:0] txQ, rxQ;
  logic [BT_W-1:0]  btQ;
  logic             offQ;

  function automatic logic [LEN_W-1:0] clampLen(input logic [LEN_W-1:0] v);
    return (v > MaxL) ? MaxL : v;
  endfunction

  function automatic logic [BT_W-1:0] floorBt(input logic [BT_W-1:0] v);
    return (v < BtMin) ? BtMin : v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txQ <= '0;
      rxQ <= '0;
    end else if (st.load) begin
      if (st.dirTx) begin
        txQ <= clampLen(txQ);
        rxQ <= '0;
      end else begin
        rxQ <= clampLen(rxQ);
        txQ <= '0;
      end
    end else if (st.count) begin
      if (st.dirTx) rxQ <= rxQ + 1'b1;
      else          txQ <= txQ + 1'b1;
    end else if (st.wrLen) begin
      txQ <= lenTxIn;
      rxQ <= lenRxIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      btQ  <= BtRst;
      offQ <= 1'b0;
    end else if (st.endResp && !offQ) begin
      btQ <= BtRst;
    end else if (btWr && !enable) begin
      if (btNoResync) begin
        btQ  <= floorBt(btIn);
        offQ <= 1'b1;
      end else begin
        btQ  <= BtRst;
        offQ <= 1'b0;
      end
    end else if (resyncValid && enable && !isMaster && !offQ && !st.endResp) begin
      btQ <= floorBt(resyncBt);
    end
  end

  assign atChecksum = (txQ == rxQ);
  assign txLen      = txQ;
  assign rxLen      = rxQ;
  assign bitTime    = btQ;
  assign resyncOff  = offQ;
endmodule

// File: rtl/lin_resp_len.sv
module lin_resp_len
  import lrl_pkg::*;
#(
  parameter int LEN_W   = 4,
  parameter int MAX_LEN = 8,
  parameter int BT_W    = 6,
  parameter int BT_RST  = 32,
  parameter int BT_MIN  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             isMaster,
  input  logic             lenWr,
  input  logic [LEN_W-1:0] lenTxIn,
  input  logic [LEN_W-1:0] lenRxIn,
  input  logic             cmdStart,
  input  logic             cmdTx,
  input  logic             byteDone,
  input  logic             byteErr,
  input  logic             btWr,
  input  logic [BT_W-1:0]  btIn,
  input  logic             btNoResync,
  input  logic             resyncValid,
  input  logic [BT_W-1:0]  resyncBt,
  output logic [LEN_W-1:0] txLen,
  output logic [LEN_W-1:0] rxLen,
  output logic             isChecksum,
  output logic             busy,
  output logic             respDone,
  output logic [BT_W-1:0]  bitTime,
  output logic             resyncOff
);
  lrlStrobe_t st;
  logic       atChecksum;

  lrl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lenWr(lenWr), .cmdStart(cmdStart), .cmdTx(cmdTx),
    .byteDone(byteDone), .byteErr(byteErr), .atChecksum(atChecksum),
    .st(st), .busy(busy), .respDone(respDone)
  );

  lrl_dp #(
    .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .BT_W(BT_W), .BT_RST(BT_RST), .BT_MIN(BT_MIN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .lenTxIn(lenTxIn), .lenRxIn(lenRxIn),
    .enable(enable), .isMaster(isMaster), .btWr(btWr), .btIn(btIn),
    .btNoResync(btNoResync), .resyncValid(resyncValid), .resyncBt(resyncBt),
    .txLen(txLen), .rxLen(rxLen), .bitTime(bitTime), .resyncOff(resyncOff),
    .atChecksum(atChecksum)
  );

  assign isChecksum = busy && atChecksum;
endmodule

// File: rtl/lin_resp_len_chk.sv
module lin_resp_len_chk #(
  parameter int LEN_W = 4,
  parameter int BT_W  = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             isMaster,
  input logic             lenWr,
  input logic [LEN_W-1:0] lenTxIn,
  input logic [LEN_W-1:0] lenRxIn,
  input logic             cmdStart,
  input logic             cmdTx,
  input logic             byteDone,
  input logic             byteErr,
  input logic             btWr,
  input logic [BT_W-1:0]  btIn,
  input logic             btNoResync,
  input logic             resyncValid,
  input logic [BT_W-1:0]  resyncBt,
  input logic [LEN_W-1:0] txLen,
  input logic [LEN_W-1:0] rxLen,
  input logic             isChecksum,
  input logic             busy,
  input logic             respDone,
  input logic [BT_W-1:0]  bitTime,
  input logic             resyncOff
);
  a_r3_fields_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (txLen <= 4'd8 && rxLen <= 4'd8));

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    respDone |-> !busy);

  a_r7_error_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && byteErr && !cmdStart) |=> (!busy && !respDone && $stable(txLen) && $stable(rxLen)));

  a_r9_bt_floor: assert property (@(posedge clk) disable iff (!rstN)
    bitTime >= 6'd8);

  a_r9_enabled_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !busy && !resyncValid) |=> ($stable(bitTime) && $stable(resyncOff)));

  a_r10_master_no_resync: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && enable && !busy) |=> $stable(bitTime));

  a_r5_checksum_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    isChecksum |-> busy);
endmodule

bind lin_resp_len lin_resp_len_chk #(.LEN_W(LEN_W), .BT_W(BT_W)) u_chk (.*);

// File: tb/lin_resp_len_bench.sv
module lin_resp_len_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam int VLEN[NVEC] = '{0, 1, 3, 8, 9, 15, 5, 2};
  localparam int VEXP[NVEC] = '{0, 1, 3, 8, 8, 8, 5, 2};

  logic clk = 1'b0, rstN = 1'b0;
  logic enable = 1'b1, isMaster = 1'b0, lenWr = 1'b0, cmdStart = 1'b0, cmdTx = 1'b0;
  logic byteDone = 1'b0, byteErr = 1'b0, btWr = 1'b0, btNoResync = 1'b0, resyncValid = 1'b0;
  logic [3:0] lenTxIn = '0, lenRxIn = '0;
  logic [5:0] btIn = '0, resyncBt = '0;
  logic [3:0] txLen, rxLen;
  logic isChecksum, busy, respDone, resyncOff;
  logic [5:0] bitTime;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_resp_len u_lin_resp_len (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic writeLen(int tx, int rx);
    lenTxIn = 4'(tx); lenRxIn = 4'(rx); lenWr = 1'b1; tick(); lenWr = 1'b0;
  endtask

  task automatic start(bit tx);
    cmdTx = tx; cmdStart = 1'b1; tick(); cmdStart = 1'b0;
  endtask

  task automatic oneByte();
    byteDone = 1'b1; tick(); byteDone = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R1 txLen", txLen, 0); check("R1 rxLen", rxLen, 0);
    check("R1 busy", busy, 0); check("R1 respDone", respDone, 0);
    check("R1 bitTime", bitTime, 32); check("R1 resyncOff", resyncOff, 0);
    rstN = 1'b1; tick();

    for (int i = 0; i < NVEC; i++) begin
      bit tx = bit'(i % 2);
      int ln = VLEN[i], ex = VEXP[i];
      if (tx) writeLen(ln, 7); else writeLen(7, ln);
      check("R2 raw", tx ? txLen : rxLen, ln);
      start(tx);
      check("R3 busy", busy, 1);
      check("R3 clamp", tx ? txLen : rxLen, ex);
      check("R3 opposite", tx ? rxLen : txLen, 0);
      for (int k = 0; k < ex; k++) begin
        check("R5 data byte", isChecksum, 0);
        oneByte();
        check("R4 count", tx ? rxLen : txLen, k + 1);
      end
      check("R5 checksum", isChecksum, 1);
      oneByte();
      check("R6 busy", busy, 0); check("R6 respDone", respDone, 1);
      check("R6 count kept", tx ? rxLen : txLen, ex);
      check("R8 reload", bitTime, 32);
      tick();
      check("R6 pulse", respDone, 0);
    end

    // R10: slave resync, floor, master ignored
    resyncBt = 6'd20; resyncValid = 1'b1; tick(); resyncValid = 1'b0;
    check("R10 resync", bitTime, 20);
    resyncBt = 6'd3; resyncValid = 1'b1; tick(); resyncValid = 1'b0;
    check("R10 floor", bitTime, 8);
    isMaster = 1'b1; resyncBt = 6'd40; resyncValid = 1'b1; tick(); resyncValid = 1'b0;
    isMaster = 1'b0;
    check("R10 master", bitTime, 8);

    // R8: reload after a checksum-only receive
    writeLen(0, 0); start(1'b0);
    check("R5 len0", isChecksum, 1);
    oneByte();
    check("R8 reload", bitTime, 32);

    // R10: reload wins over resync in the same cycle
    resyncBt = 6'd20; resyncValid = 1'b1; tick(); resyncValid = 1'b0;
    start(1'b1);
    resyncBt = 6'd40; resyncValid = 1'b1; byteDone = 1'b1; tick();
    resyncValid = 1'b0; byteDone = 1'b0;
    check("R10 reload wins", bitTime, 32);

    // R7: error mid-response
    writeLen(5, 0); start(1'b1); oneByte(); oneByte();
    resyncBt = 6'd20; resyncValid = 1'b1; tick(); resyncValid = 1'b0;
    byteErr = 1'b1; tick(); byteErr = 1'b0;
    check("R7 busy", busy, 0); check("R7 respDone", respDone, 0);
    check("R7 progress", rxLen, 2); check("R7 length", txLen, 5);
    check("R8 reload on error", bitTime, 32);

    // R9: writes while enabled ignored, while disabled applied
    btIn = 6'd12; btNoResync = 1'b1; btWr = 1'b1; tick(); btWr = 1'b0;
    check("R9 enabled bt", bitTime, 32); check("R9 enabled off", resyncOff, 0);
    enable = 1'b0;
    btWr = 1'b1; tick(); btWr = 1'b0;
    check("R9 store bt", bitTime, 12); check("R9 set off", resyncOff, 1);
    btIn = 6'd4; btWr = 1'b1; tick(); btWr = 1'b0;
    check("R9 floor", bitTime, 8);
    enable = 1'b1;
    resyncBt = 6'd30; resyncValid = 1'b1; tick(); resyncValid = 1'b0;
    check("R10 off ignored", bitTime, 8);

    // R8: resyncOff keeps bitTime; R2: lenWr while busy ignored
    writeLen(0, 2); start(1'b0);
    writeLen(9, 9);
    check("R2 busy tx", txLen, 0); check("R2 busy rx", rxLen, 2);
    // R11: cmdStart beats byteDone
    cmdTx = 1'b0; cmdStart = 1'b1; byteDone = 1'b1; tick();
    cmdStart = 1'b0; byteDone = 1'b0;
    check("R11 restart count", txLen, 0); check("R11 busy", busy, 1);
    oneByte(); oneByte(); oneByte();
    check("R6 done", respDone, 1);
    check("R8 kept", bitTime, 8);

    enable = 1'b0;
    btIn = 6'd50; btNoResync = 1'b0; btWr = 1'b1; tick(); btWr = 1'b0;
    check("R9 force bt", bitTime, 32); check("R9 clear off", resyncOff, 0);
    enable = 1'b1;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule